// File: doc/BRIEF.md
# Two-Stage Fetch Front End with Redirect Flush

This block owns the program counter and the boundary register between the fetch and execute stages of a two-stage in-order core. Each cycle it presents the fetch PC as the instruction-memory address. It expects the memory to return the instruction word combinationally in the same cycle. On the next clock edge it moves that word, together with the PC it was fetched from, into the execute stage. Decode, execution, register write-back and memory access all happen in that single execute cycle, outside this block.

No branch prediction is done. When the execute stage resolves a taken branch or runs a jump, it raises a redirect request with the target address. On that edge the block loads the target into the fetch PC. It also discards the instruction fetched along the wrong path and places the fixed no-operation word `0x00000013` in the execute slot instead. A branch that is not taken raises no redirect, so the fetched word flows on untouched.

Both the execute-slot register and the fetch PC are set by reset. The first execute cycle therefore runs a no-operation, and an instruction's register effects appear two cycles after its address is issued.

Top module: `fetch_front`

## Requirements
- R1: On a clock edge with `rst` high, `imem_addr` becomes `RESET_PC` (0 by default), `ex_pc` becomes `RESET_PC`, and `ex_instr` becomes the no-operation word `0x00000013`.
- R2: On an edge with `rst` and `redir_valid` both low, `imem_addr` advances by `ILEN/8` bytes (4 by default).
- R3: On an edge with `rst` and `redir_valid` both low, `ex_instr` takes the `imem_rdata` value present before the edge.
- R4: On an edge with `redir_valid` high and `rst` low, `imem_addr` becomes the `redir_target` value present before the edge.
- R5: On an edge with `redir_valid` high and `rst` low, `ex_instr` becomes `0x00000013`, whatever `imem_rdata` holds.
- R6: On every edge with `rst` low, `ex_pc` takes the `imem_addr` value present before the edge. On a flush this is the address of the discarded fetch.
- R7: `rst` takes priority over `redir_valid`. A redirect presented while `rst` is high leaves the state at its reset values.
- R8: Back-to-back redirects each take effect. A cycle with `redir_valid` low directly after a flush passes the fetched word through with no further flush.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | XLEN | Fetch address to instruction memory |
| imem_rdata | input | ILEN | Instruction word returned for `imem_addr` in the same cycle |
| redir_valid | input | 1 | Execute-stage request to redirect (taken branch or jump) |
| redir_target | input | XLEN | Redirect destination address |
| ex_instr | output | ILEN | Instruction held for the execute stage |
| ex_pc | output | XLEN | Fetch address of the instruction in `ex_instr` |

## Verification
The bench builds the block with its defaults: 32-bit addresses, 32-bit instructions, a 4-byte step and a reset PC of zero. Its memory model returns a word derived from the address, so each passed-through instruction can be told apart from the no-operation word and from its neighbours. With these values, a redirect to the address that sequential fetch would have reached anyway becomes reachable. So do redirects back to zero and to the top of the address space, where PC+4 would wrap. In each of these cases, only the no-operation word in the execute slot shows that a flush occurred.

// File: rtl/fetch_front.sv
module fetch_front #(
  parameter int XLEN = 32,
  parameter int ILEN = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0,
  parameter logic [ILEN-1:0] NOP_WORD = ILEN'(32'h0000_0013)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] imem_addr,
  input  logic [ILEN-1:0] imem_rdata,
  input  logic            redir_valid,
  input  logic [XLEN-1:0] redir_target,
  output logic [ILEN-1:0] ex_instr,
  output logic [XLEN-1:0] ex_pc
);
  localparam logic [XLEN-1:0] STEP = XLEN'(ILEN / 8);

  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] pc_next;
  logic [ILEN-1:0] slot_next;

  assign pc_next   = redir_valid ? redir_target : pc_q + STEP;
  assign slot_next = redir_valid ? NOP_WORD : imem_rdata;
  assign imem_addr = pc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= RESET_PC;
      ex_instr <= NOP_WORD;
      ex_pc    <= RESET_PC;
    end else begin
      pc_q     <= pc_next;
      ex_instr <= slot_next;
      ex_pc    <= pc_q;
    end
  end
endmodule

// File: rtl/fetch_front_chk.sv
module fetch_front_chk #(
  parameter int XLEN = 32,
  parameter int ILEN = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0,
  parameter logic [ILEN-1:0] NOP_WORD = ILEN'(32'h0000_0013)
) (
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] imem_addr,
  input logic [ILEN-1:0] imem_rdata,
  input logic            redir_valid,
  input logic [XLEN-1:0] redir_target,
  input logic [ILEN-1:0] ex_instr,
  input logic [XLEN-1:0] ex_pc
);
  localparam logic [XLEN-1:0] STEP = XLEN'(ILEN / 8);

  logic seen = 1'b0;
  always_ff @(posedge clk) seen <= 1'b1;

  p_reset_r1: assert property (@(posedge clk)
    seen && $past(rst) |-> imem_addr == RESET_PC && ex_pc == RESET_PC && ex_instr == NOP_WORD);

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    seen && !$past(rst) && !$past(redir_valid) |-> imem_addr == $past(imem_addr) + STEP);

  p_pass_r3: assert property (@(posedge clk) disable iff (rst)
    seen && !$past(rst) && !$past(redir_valid) |-> ex_instr == $past(imem_rdata));

  p_target_r4: assert property (@(posedge clk) disable iff (rst)
    seen && !$past(rst) && $past(redir_valid) |-> imem_addr == $past(redir_target));

  p_flush_r5: assert property (@(posedge clk) disable iff (rst)
    seen && !$past(rst) && $past(redir_valid) |-> ex_instr == NOP_WORD);

  p_expc_r6: assert property (@(posedge clk) disable iff (rst)
    seen && !$past(rst) |-> ex_pc == $past(imem_addr));
endmodule

bind fetch_front fetch_front_chk #(
  .XLEN(XLEN), .ILEN(ILEN), .RESET_PC(RESET_PC), .NOP_WORD(NOP_WORD)
) u_chk (.*);

// File: tb/fetch_front_tb.sv
module fetch_front_tb;
  localparam logic [31:0] NOP = 32'h0000_0013;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr;
  logic [31:0] imem_rdata;
  logic        redir_valid = 1'b0;
  logic [31:0] redir_target = '0;
  logic [31:0] ex_instr;
  logic [31:0] ex_pc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return 32'hC0DE_0000 ^ {a[15:0], a[31:16]} ^ 32'h0000_0F00;
  endfunction

  assign imem_rdata = mem_word(imem_addr);

  fetch_front u_dut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .redir_valid(redir_valid), .redir_target(redir_target),
    .ex_instr(ex_instr), .ex_pc(ex_pc)
  );

  // {redirect, target}
  localparam logic [32:0] VEC [14] = '{
    {1'b0, 32'h0}, {1'b0, 32'h0}, {1'b1, 32'h0000_0100},
    {1'b0, 32'h0}, {1'b1, 32'h0000_0040}, {1'b1, 32'h0000_0080},
    {1'b0, 32'h0}, {1'b1, 32'h0000_0088}, {1'b0, 32'h0},
    {1'b1, 32'hFFFF_FFFC}, {1'b0, 32'h0}, {1'b0, 32'h0},
    {1'b1, 32'h0000_0000}, {1'b0, 32'h0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [31:0] e_pc, e_ins, e_expc;

  initial begin
    // R7: redirect while in reset is ignored
    redir_valid  = 1'b1;
    redir_target = 32'h0000_0500;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 imem_addr", imem_addr, 32'h0);
    chk("R1 ex_instr", ex_instr, NOP);
    chk("R1 ex_pc", ex_pc, 32'h0);
    chk("R7 reset beats redirect", imem_addr, 32'h0);
    redir_valid = 1'b0;
    rst = 1'b0;
    e_pc = 32'h0;
    for (int i = 0; i < 14; i++) begin
      redir_valid  = VEC[i][32];
      redir_target = VEC[i][31:0];
      if (VEC[i][32]) begin
        e_ins = NOP;
        e_expc = e_pc;
        e_pc = VEC[i][31:0];
      end else begin
        e_ins = mem_word(e_pc);
        e_expc = e_pc;
        e_pc = e_pc + 32'd4;
      end
      @(negedge clk);
      chk(VEC[i][32] ? "R4 target" : "R2 step", imem_addr, e_pc);
      chk(VEC[i][32] ? "R5 flush nop" : "R3 R8 pass-through", ex_instr, e_ins);
      chk("R6 ex_pc", ex_pc, e_expc);
    end
    // R7: mid-run reset with redirect asserted
    redir_valid  = 1'b1;
    redir_target = 32'h0000_0700;
    rst = 1'b1;
    @(negedge clk);
    chk("R7 addr", imem_addr, 32'h0);
    chk("R7 ex_instr", ex_instr, NOP);
    rst = 1'b0;
    redir_valid = 1'b0;
    @(negedge clk);
    chk("R3 first word after reset", ex_instr, mem_word(32'h0));
    chk("R2 step after reset", imem_addr, 32'h4);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule